// File: doc/BRIEF.md
# Interrupt Gate with Set/Clear Enable Pair

This block gathers one-cycle event pulses from a USB host controller core into a sticky status register and combines them with a per-event enable register and a master enable to produce one level interrupt. Software reaches it through a small register bus. Each access carries an 8-bit command code, and bit 7 of that code marks a write.

The enable register has two addresses. Writing ones at the enable address turns the matching enables on. Writing ones at the disable address turns them off. The disable address has no storage of its own: reading it returns the live enable register. Enable bit 31 is the master enable. When it is low, no interrupt reaches the output, whatever the other bits hold. The interrupt output is registered.

Top module: `usb_irq_gate`

## Requirements
- R1: After reset, reads of the status (code 03h), enable (code 04h) and disable (code 05h) addresses return 0, and `irq_o` is low.
- R2: A write with code 84h sets every enable bit where `wdata` is 1. Bits where `wdata` is 0 keep their value.
- R3: A write with code 85h clears every enable bit where `wdata` is 1. Bits where `wdata` is 0 keep their value, and this includes the master enable in bit 31.
- R4: A read with code 05h returns the same value as a read with code 04h, which is the current enable register.
- R5: Status bits are defined at these positions: bit 6 root hub change, bit 5 frame number overflow, bit 4 unrecoverable error, bit 3 resume detect, bit 2 start-of-frame, bit 0 scheduling overrun. A pulse on `ev_pulse[b]` at a defined position sets status bit b. A write with code 83h clears each status bit where `wdata` is 1. Code 03h reads the status register.
- R6: If an event pulse and a status-clearing write hit the same bit in the same cycle, the bit ends up set.
- R7: Reserved bits (1 and 7 to 30 in status; 1 and 7 to 30 in enable, and bit 31 in status) read as 0. Writes and event pulses do not change them. A read with any other code returns 0.
- R8: `irq_o` goes high exactly when the master enable is 1 and some defined bit is set in both status and enable. It follows a register update by one clock.
- R9: While the master enable (enable bit 31) is 0, `irq_o` stays low for every status and enable pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Register access in this cycle |
| cmd_code | input | 8 | Command code: bit 7 = write, bits 6:0 = register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for a valid read in the same cycle, else 0 |
| ev_pulse | input | 32 | One-cycle event pulses, one per status bit position |
| irq_o | output | 1 | Registered level interrupt |

## Verification
The bench builds the block with its default parameters: a 32-bit register, the six defined events at bits 0 and 2 to 6, and the master enable in bit 31. This shape reduces the interrupt function to seven enable bits and six status bits. The bench therefore sweeps all 128 enable patterns against all 64 status patterns and predicts `irq_o` for each pair from the stated rule. Directed cases cover the one-clock output latency, the set-wins collision, zero-bit writes at both enable addresses, and writes to reserved bits.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;

  localparam int unsigned CMD_W  = 8;
  localparam int unsigned ADDR_W = CMD_W - 1;

  // register addresses (bit 7 of the command code selects write)
  localparam logic [ADDR_W-1:0] ADDR_STATUS  = 7'h03;
  localparam logic [ADDR_W-1:0] ADDR_ENABLE  = 7'h04;
  localparam logic [ADDR_W-1:0] ADDR_DISABLE = 7'h05;

  typedef enum logic [1:0] {
    RSEL_NONE   = 2'd0,
    RSEL_STATUS = 2'd1,
    RSEL_ENABLE = 2'd2
  } rsel_e;

  typedef struct packed {
    logic wr_status;
    logic wr_enable;
    logic wr_disable;
  } wstrb_t;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode
  import usb_irq_pkg::*;
(
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_code,
  output wstrb_t           wstrb,
  output rsel_e            rsel
);

  localparam int unsigned WR_BIT = CMD_W - 1;

  logic              is_wr;
  logic [ADDR_W-1:0] addr;

  assign is_wr = cmd_code[WR_BIT];
  assign addr  = cmd_code[ADDR_W-1:0];

  always_comb begin
    wstrb = '0;
    rsel  = RSEL_NONE;
    if (cmd_valid) begin
      if (is_wr) begin
        wstrb.wr_status  = (addr == ADDR_STATUS);
        wstrb.wr_enable  = (addr == ADDR_ENABLE);
        wstrb.wr_disable = (addr == ADDR_DISABLE);
      end else begin
        unique case (addr)
          ADDR_STATUS:  rsel = RSEL_STATUS;
          ADDR_ENABLE,
          ADDR_DISABLE: rsel = RSEL_ENABLE;
          default:      rsel = RSEL_NONE;
        endcase
      end
    end
  end

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned      DATA_W   = 32,
  parameter logic [DATA_W-1:0] EVT_MASK = 32'h0000_007D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] ev_pulse,
  output logic [DATA_W-1:0] stat_q
);

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (EVT_MASK[b]) begin : g_live
      logic bit_q;
      logic bit_d;
      logic bit_ce;
      logic clr_hit;

      // an event in the same cycle as a clear keeps the bit set
      always_comb begin
        clr_hit = clr_wr & wdata[b];
        bit_ce  = ev_pulse[b] | clr_hit;
        bit_d   = ev_pulse[b] | (bit_q & ~clr_hit);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          bit_q <= 1'b0;
        end else if (bit_ce) begin
          bit_q <= bit_d;
        end
      end

      assign stat_q[b] = bit_q;
    end else begin : g_rsvd
      assign stat_q[b] = 1'b0;
    end
  end

endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank #(
  parameter int unsigned       DATA_W  = 32,
  parameter logic [DATA_W-1:0] EN_MASK = 32'h8000_007D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_wr,
  input  logic              clr_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] en_q
);

  logic [DATA_W-1:0] en_d;
  logic [DATA_W-1:0] hit;
  logic              en_ce;

  always_comb begin
    hit   = wdata & EN_MASK;
    en_ce = set_wr | clr_wr;
    en_d  = en_q;
    if (set_wr) begin
      en_d = en_d | hit;
    end
    if (clr_wr) begin
      en_d = en_d & ~hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_ce) begin
      en_q <= en_d;
    end
  end

endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int unsigned       DATA_W   = 32,
  parameter int unsigned       MIE_BIT  = 31,
  parameter logic [DATA_W-1:0] EVT_MASK = 32'h0000_007D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] stat_q,
  input  logic [DATA_W-1:0] en_q,
  output logic              irq_o
);

  logic irq_q;
  logic irq_d;
  logic irq_ce;

  always_comb begin
    irq_d  = en_q[MIE_BIT] & (|(stat_q & en_q & EVT_MASK));
    irq_ce = irq_d ^ irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else if (irq_ce) begin
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/usb_irq_gate.sv
module usb_irq_gate
  import usb_irq_pkg::*;
#(
  parameter int unsigned       DATA_W    = 32,
  parameter int unsigned       MIE_BIT   = 31,
  parameter logic [DATA_W-1:0] EVT_MASK  = 32'h0000_007D,
  parameter int unsigned       RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_code,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] ev_pulse,
  output logic              irq_o
);

  localparam logic [DATA_W-1:0] MIE_MASK = DATA_W'(1) << MIE_BIT;
  localparam logic [DATA_W-1:0] EN_MASK  = EVT_MASK | MIE_MASK;

  logic              rst_sync_n;
  wstrb_t            wstrb;
  rsel_e             rsel;
  logic [DATA_W-1:0] stat_q;
  logic [DATA_W-1:0] en_q;

  irq_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irq_cmd_decode u_dec (
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .wstrb     (wstrb),
    .rsel      (rsel)
  );

  irq_status_bank #(.DATA_W(DATA_W), .EVT_MASK(EVT_MASK)) u_stat (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr_wr   (wstrb.wr_status),
    .wdata    (wdata),
    .ev_pulse (ev_pulse),
    .stat_q   (stat_q)
  );

  irq_enable_bank #(.DATA_W(DATA_W), .EN_MASK(EN_MASK)) u_en (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_wr (wstrb.wr_enable),
    .clr_wr (wstrb.wr_disable),
    .wdata  (wdata),
    .en_q   (en_q)
  );

  irq_out_stage #(.DATA_W(DATA_W), .MIE_BIT(MIE_BIT), .EVT_MASK(EVT_MASK)) u_out (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .stat_q (stat_q),
    .en_q   (en_q),
    .irq_o  (irq_o)
  );

  // disable address has no storage: it reads back the enable register
  always_comb begin
    unique case (rsel)
      RSEL_STATUS: rdata = stat_q;
      RSEL_ENABLE: rdata = en_q;
      default:     rdata = '0;
    endcase
  end

endmodule

// File: rtl/irq_gate_checker.sv
module irq_gate_checker #(
  parameter int unsigned       DATA_W   = 32,
  parameter int unsigned       MIE_BIT  = 31,
  parameter logic [DATA_W-1:0] EVT_MASK = 32'h0000_007D
) (
  input logic              clk,
  input logic              rst_q,
  input logic              cmd_valid,
  input logic [7:0]        cmd_code,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [DATA_W-1:0] ev_pulse,
  input logic              irq_o,
  input logic [DATA_W-1:0] stat_q,
  input logic [DATA_W-1:0] en_q
);

  localparam logic [DATA_W-1:0] EN_MASK = EVT_MASK | (DATA_W'(1) << MIE_BIT);

  logic wr_en, wr_dis, wr_st, rd_dis;
  assign wr_en  = cmd_valid && (cmd_code == 8'h84);
  assign wr_dis = cmd_valid && (cmd_code == 8'h85);
  assign wr_st  = cmd_valid && (cmd_code == 8'h83);
  assign rd_dis = cmd_valid && (cmd_code == 8'h05);

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(rst_q) |-> (stat_q == '0 && en_q == '0 && !irq_o));

  p_enable_set_r2: assert property (@(posedge clk) disable iff (!rst_q)
    wr_en |=> ((en_q & $past(wdata & EN_MASK)) == $past(wdata & EN_MASK)));

  p_disable_clear_r3: assert property (@(posedge clk) disable iff (!rst_q)
    wr_dis |=> ((en_q & $past(wdata)) == '0));

  p_disable_read_r4: assert property (@(posedge clk) disable iff (!rst_q)
    rd_dis |-> (rdata == en_q));

  p_event_sets_r5: assert property (@(posedge clk) disable iff (!rst_q)
    (|(ev_pulse & EVT_MASK)) |=> ((stat_q & $past(ev_pulse & EVT_MASK)) == $past(ev_pulse & EVT_MASK)));

  // R6: a same-cycle clear never removes a bit that is being set
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_st && |(ev_pulse & wdata & EVT_MASK)) |=> ((stat_q & $past(ev_pulse & wdata & EVT_MASK)) != '0));

  p_reserved_zero_r7: assert property (@(posedge clk) disable iff (!rst_q)
    ((stat_q & ~EVT_MASK) == '0) && ((en_q & ~EN_MASK) == '0));

  p_irq_needs_event_r8: assert property (@(posedge clk) disable iff (!rst_q)
    irq_o |-> $past(|(stat_q & en_q & EVT_MASK)));

  p_master_gate_r9: assert property (@(posedge clk) disable iff (!rst_q)
    irq_o |-> $past(en_q[MIE_BIT]));

endmodule

bind usb_irq_gate irq_gate_checker #(
  .DATA_W   (DATA_W),
  .MIE_BIT  (MIE_BIT),
  .EVT_MASK (EVT_MASK)
) u_chk (
  .clk       (clk),
  .rst_q     (rst_sync_n),
  .cmd_valid (cmd_valid),
  .cmd_code  (cmd_code),
  .wdata     (wdata),
  .rdata     (rdata),
  .ev_pulse  (ev_pulse),
  .irq_o     (irq_o),
  .stat_q    (stat_q),
  .en_q      (en_q)
);

// File: tb/test_usb_irq_gate.sv
`timescale 1ns/1ps
module test_usb_irq_gate;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [7:0]  cmd_code;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [31:0] ev_pulse;
  logic        irq_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  usb_irq_gate i_usb_irq_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .wdata     (wdata),
    .rdata     (rdata),
    .ev_pulse  (ev_pulse),
    .irq_o     (irq_o)
  );

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] code, input logic [31:0] data);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = code; wdata = data;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_code = '0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] code, output logic [31:0] data);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = code;
    #1 data = rdata;
    cmd_valid = 1'b0; cmd_code = '0;
  endtask

  task automatic pulse(input logic [31:0] ev);
    @(negedge clk);
    ev_pulse = ev;
    @(negedge clk);
    ev_pulse = '0;
  endtask

  // compact 6-bit event index -> register bit positions 0,2,3,4,5,6
  function automatic logic [31:0] spread(input logic [5:0] c);
    return {25'd0, c[5:1], 1'b0, c[0]};
  endfunction

  task automatic wait_one();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] v, v2;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_code = '0; wdata = '0; ev_pulse = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(8'h03, v); check32("R1 status", v, 0);
    rd(8'h04, v); check32("R1 enable", v, 0);
    rd(8'h05, v); check32("R1 disable read", v, 0);
    check32("R1 irq", {31'd0, irq_o}, 0);

    // R2 set through enable address
    wr(8'h84, 32'h0000_0005); rd(8'h04, v); check32("R2 set", v, 32'h5);
    wr(8'h84, 32'h0); rd(8'h04, v); check32("R2 zero write", v, 32'h5);
    wr(8'h84, 32'hFFFF_FFFF); rd(8'h04, v); check32("R2 R7 all ones", v, 32'h8000_007D);

    // R3 clear through disable address, R4 readback
    wr(8'h85, 32'h1); rd(8'h04, v); check32("R3 clear bit0", v, 32'h8000_007C);
    wr(8'h85, 32'h0); rd(8'h04, v); check32("R3 zero write incl master", v, 32'h8000_007C);
    rd(8'h05, v2); check32("R4 disable reads enable", v2, v);
    wr(8'h85, 32'h8000_0000); rd(8'h05, v); check32("R3 R4 master cleared", v, 32'h7C);
    wr(8'h85, 32'hFFFF_FFFF); rd(8'h05, v); check32("R3 all cleared", v, 0);

    // R5 status set / clear
    pulse(32'h8); rd(8'h03, v); check32("R5 event sets", v, 32'h8);
    wr(8'h83, 32'h0); rd(8'h03, v); check32("R5 zero clear write", v, 32'h8);
    wr(8'h83, 32'h8); rd(8'h03, v); check32("R5 clear", v, 0);

    // R6 collision: event on bit 2 with clear of bits 2 and 3, bit 3 set beforehand
    pulse(32'h8);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = 8'h83; wdata = 32'hC; ev_pulse = 32'h4;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_code = '0; wdata = '0; ev_pulse = '0;
    rd(8'h03, v); check32("R6 set wins", v, 32'h4);
    wr(8'h83, 32'hFFFF_FFFF);

    // R7 reserved bits and unknown codes
    pulse(32'hFFFF_FFFF); rd(8'h03, v); check32("R7 status reserved", v, 32'h7D);
    rd(8'h10, v); check32("R7 unknown code", v, 0);
    wr(8'h83, 32'hFFFF_FFFF); rd(8'h03, v); check32("R7 status cleared", v, 0);

    // R8 one-clock latency
    wr(8'h84, 32'h8000_0008);
    pulse(32'h8);
    check32("R8 not yet", {31'd0, irq_o}, 0);
    wait_one();
    check32("R8 asserted", {31'd0, irq_o}, 1);
    wr(8'h85, 32'h8);
    check32("R8 still high", {31'd0, irq_o}, 1);
    wait_one();
    check32("R8 dropped", {31'd0, irq_o}, 0);

    // R8 / R9 exhaustive sweep: 7 enable bits x 6 status bits
    for (int e = 0; e < 128; e++) begin
      for (int s = 0; s < 64; s++) begin
        logic [31:0] en_w;
        logic        exp_irq;
        en_w = spread(e[5:0]) | (e[6] ? 32'h8000_0000 : 32'h0);
        exp_irq = e[6] && ((e[5:0] & s[5:0]) != 6'd0);
        wr(8'h85, 32'hFFFF_FFFF);
        wr(8'h83, 32'hFFFF_FFFF);
        wr(8'h84, en_w);
        pulse(spread(s[5:0]));
        wait_one();
        if (e[6]) check32("R8 sweep irq", {31'd0, irq_o}, {31'd0, exp_irq});
        else      check32("R9 master off irq", {31'd0, irq_o}, 0);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule